// File: doc/BRIEF.md
# Slew-Rate Calibration Sequencer

This block calibrates the high-speed transmit edge rate of one port without any software involvement. A one-cycle start request names the port. The sequencer then enables that port's ring oscillator and waits for it to settle. Next it runs the shared frequency meter on the selected port and polls the meter's valid flag at a fixed interval, giving up after a bounded time. The count it reads back is turned into a 3-bit slew-rate code. That code is driven to the port's slew control field, the oscillator is switched off and a one-cycle done pulse is raised.

The code is round((WINDOW × REF_MHZ × COEF) / count / ROUND_DIV), where the inner quotient is floored and the outer division rounds to nearest. The defaults are WINDOW = 1024, REF_MHZ = 26, COEF = 28 and ROUND_DIV = 1000, which gives a numerator of 745472. Only the low 3 bits of the result are kept. A count of zero, whether reported as valid or left behind by a timeout, selects the default code. Both divisions run on a single multi-cycle restoring divider. The settling, poll and timeout intervals are cycle counts set by parameters; the defaults assume a 26 MHz clock (1 µs, 10 µs and 200 µs).

Top module: `srcal_seq`

## Requirements
- R1: After reset, osc_en_o, meter_en_o and done_o are 0, meter_sel_o is 0, and slew_code_o holds DEFAULT_CODE (4), which is the power-up preset of the field.
- R2: A start_i seen while idle captures port_idx_i onto meter_sel_o and raises osc_en_o in the next cycle. osc_en_o then stays high for exactly SETTLE_CYC cycles with meter_en_o low before measurement begins.
- R3: During measurement meter_en_o is high. Let cycles be numbered i = 0, 1, … from the first measuring cycle. meter_valid_i is sampled only in cycles where (i+1) is a multiple of POLL_CYC, and a valid level in any other cycle has no effect.
- R4: If valid is not seen, measurement ends at the first poll cycle with i+1 ≥ TIMEOUT_CYC, and the sequencer continues with whatever meter_count_i holds in that cycle.
- R5: For a nonzero count c captured at the end of measurement, the new code is bits 2:0 of ((745472 / c) + 500) / 1000, where both divisions are integer floor divisions. For example, c = 1024 gives 1, c = 90 gives 0, c = 497 gives 1 and c = 496 gives 2.
- R6: A captured count of zero makes the new code DEFAULT_CODE (4). This holds both after a valid flag and after a timeout.
- R7: With a nonzero count, the new code appears 2×DIV_W+2 = 42 clock edges after the edge that ends measurement, and osc_en_o stays high throughout. With a zero count, the code appears on the edge that ends measurement.
- R8: osc_en_o stays high for one more cycle after the new code appears. In the following cycle osc_en_o is 0 and done_o is 1 for exactly one cycle, and then the sequencer is idle.
- R9: A start_i that arrives while a calibration is in progress is ignored: meter_sel_o and the timing of the running sequence are unchanged.
- R10: slew_code_o changes only while osc_en_o is high, and it holds its value between calibrations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Calibration request, one cycle |
| port_idx_i | input | PORT_W | Port to calibrate |
| meter_valid_i | input | 1 | Frequency meter result valid |
| meter_count_i | input | CNT_W | Frequency meter count |
| osc_en_o | output | 1 | Ring oscillator enable for the port |
| meter_en_o | output | 1 | Frequency meter run enable |
| meter_sel_o | output | PORT_W | Port channel selected at the meter |
| slew_code_o | output | 3 | Slew-rate code to the port's control field |
| done_o | output | 1 | Calibration finished, one cycle |

## Verification
The bench drives rounding neighbours (496 and 497) and a count whose result exceeds 7 (90). A divider that rounds wrongly or saturates instead of truncating shows up there as codes that are off by one or stuck at 7. Valid pulses that fall between poll instants and timeouts that end with zero or nonzero counts are also driven. A design that samples valid on every cycle, or that ignores the count present at timeout, would end measurement early or write the wrong code. Start requests that arrive mid-run, and off-by-one settle or divider latencies, are caught by the cycle-exact reference compare of the oscillator, meter, done and select outputs.

// File: rtl/srcal_pkg.sv
package srcal_pkg;

   localparam int CODE_W = 3;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SETTLE = 3'd1,
      ST_MEAS   = 3'd2,
      ST_DIV    = 3'd3,
      ST_HOLD   = 3'd4,
      ST_DONE   = 3'd5
   } srcal_state_e;

endpackage

// File: rtl/srcal_div.sv
// Restoring divider: one quotient bit per cycle, done one cycle after the last step.
module srcal_div #(
   parameter int W = 20
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [W-1:0] dividend_i,
   input  logic [W-1:0] divisor_i,
   output logic [W-1:0] quo_o,
   output logic         done_o
);

   localparam int STEP_W = $clog2(W + 1);

   if (W < 2) begin : g_bad_w
      $error("srcal_div: W must be at least 2");
   end

   logic [W-1:0]      rem_q, dsr_q, quo_q;
   logic [STEP_W-1:0] steps_q;
   logic              run_q;
   logic [W:0]        shifted;
   logic              fits;

   assign shifted = {rem_q, quo_q[W-1]};
   assign fits    = shifted >= {1'b0, dsr_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q   <= '0;
         dsr_q   <= '0;
         quo_q   <= '0;
         steps_q <= '0;
         run_q   <= 1'b0;
         done_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (start_i) begin
            rem_q   <= '0;
            dsr_q   <= divisor_i;
            quo_q   <= dividend_i;
            steps_q <= STEP_W'(W);
            run_q   <= 1'b1;
         end else if (run_q) begin
            if (fits) begin
               rem_q <= W'(shifted - {1'b0, dsr_q});
            end else begin
               rem_q <= shifted[W-1:0];
            end
            quo_q   <= {quo_q[W-2:0], fits};
            steps_q <= steps_q - 1'b1;
            if (steps_q == STEP_W'(1)) begin
               run_q  <= 1'b0;
               done_o <= 1'b1;
            end
         end
      end
   end

   assign quo_o = quo_q;

endmodule

// File: rtl/srcal_pace.sv
// Settle, poll and timeout counters for the sequencer.
module srcal_pace #(
   parameter int SETTLE_CYC  = 26,
   parameter int POLL_CYC    = 260,
   parameter int TIMEOUT_CYC = 5200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_settle_i,
   input  logic run_meas_i,
   output logic settle_end_o,
   output logic poll_o,
   output logic expired_o
);

   localparam int SC_W = $clog2(SETTLE_CYC + 1);
   localparam int TC_W = $clog2(TIMEOUT_CYC + POLL_CYC + 1);

   logic [SC_W-1:0] sc_q;
   logic [TC_W-1:0] tc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sc_q <= '0;
         tc_q <= '0;
      end else begin
         sc_q <= run_settle_i ? sc_q + 1'b1 : '0;
         tc_q <= run_meas_i ? tc_q + 1'b1 : '0;
      end
   end

   assign settle_end_o = run_settle_i && (sc_q == SC_W'(SETTLE_CYC - 1));
   assign expired_o    = tc_q >= TC_W'(TIMEOUT_CYC - 1);

   if (POLL_CYC == 1) begin : g_poll_every
      assign poll_o = run_meas_i;
   end else begin : g_poll_div
      localparam int PC_W = $clog2(POLL_CYC);
      logic [PC_W-1:0] pc_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pc_q <= '0;
         end else if (run_meas_i && pc_q != PC_W'(POLL_CYC - 1)) begin
            pc_q <= pc_q + 1'b1;
         end else begin
            pc_q <= '0;
         end
      end
      assign poll_o = run_meas_i && (pc_q == PC_W'(POLL_CYC - 1));
   end

endmodule

// File: rtl/srcal_seq.sv
module srcal_seq
   import srcal_pkg::*;
#(
   parameter int PORT_W       = 2,
   parameter int CNT_W        = 16,
   parameter int SETTLE_CYC   = 26,
   parameter int POLL_CYC     = 260,
   parameter int TIMEOUT_CYC  = 5200,
   parameter int WINDOW       = 1024,
   parameter int REF_MHZ      = 26,
   parameter int COEF         = 28,
   parameter int ROUND_DIV    = 1000,
   parameter int DEFAULT_CODE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [PORT_W-1:0] port_idx_i,
   input  logic              meter_valid_i,
   input  logic [CNT_W-1:0]  meter_count_i,
   output logic              osc_en_o,
   output logic              meter_en_o,
   output logic [PORT_W-1:0] meter_sel_o,
   output logic [2:0]        slew_code_o,
   output logic              done_o
);

   localparam int NUM   = WINDOW * REF_MHZ * COEF;
   localparam int HALF  = ROUND_DIV / 2;
   localparam int DIV_W = $clog2(NUM + HALF + 1);

   if (SETTLE_CYC < 1 || POLL_CYC < 1 || TIMEOUT_CYC < 1) begin : g_bad_time
      $error("srcal_seq: interval counts must be at least 1");
   end
   if (CNT_W > DIV_W || $clog2(ROUND_DIV + 1) > DIV_W) begin : g_bad_width
      $error("srcal_seq: divisor wider than the divider");
   end
   if (DEFAULT_CODE < 0 || DEFAULT_CODE >= (1 << CODE_W)) begin : g_bad_code
      $error("srcal_seq: DEFAULT_CODE does not fit the code field");
   end
   if (PORT_W < 1) begin : g_bad_port
      $error("srcal_seq: PORT_W must be at least 1");
   end

   srcal_state_e      state_q;
   logic              pass2_q;
   logic [PORT_W-1:0] port_q;
   logic [2:0]        code_q;

   logic              settle_end, poll, expired, meas_exit;
   logic              div_start, div_done;
   logic [DIV_W-1:0]  div_dividend, div_divisor, div_quo;

   srcal_pace #(
      .SETTLE_CYC (SETTLE_CYC),
      .POLL_CYC   (POLL_CYC),
      .TIMEOUT_CYC(TIMEOUT_CYC)
   ) u_pace (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_settle_i(state_q == ST_SETTLE),
      .run_meas_i  (state_q == ST_MEAS),
      .settle_end_o(settle_end),
      .poll_o      (poll),
      .expired_o   (expired)
   );

   assign meas_exit = poll && (meter_valid_i || expired);

   // First pass: NUM / count. Second pass: (quotient + HALF) / ROUND_DIV.
   assign div_start = (state_q == ST_MEAS && meas_exit && meter_count_i != '0) ||
                      (state_q == ST_DIV && div_done && !pass2_q);
   assign div_dividend = (state_q == ST_DIV) ? div_quo + DIV_W'(HALF) : DIV_W'(NUM);
   assign div_divisor  = (state_q == ST_DIV) ? DIV_W'(ROUND_DIV) : DIV_W'(meter_count_i);

   srcal_div #(.W(DIV_W)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (div_start),
      .dividend_i(div_dividend),
      .divisor_i (div_divisor),
      .quo_o     (div_quo),
      .done_o    (div_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pass2_q <= 1'b0;
         port_q  <= '0;
         code_q  <= 3'(DEFAULT_CODE);
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  port_q  <= port_idx_i;
                  state_q <= ST_SETTLE;
               end
            end
            ST_SETTLE: begin
               if (settle_end) state_q <= ST_MEAS;
            end
            ST_MEAS: begin
               if (meas_exit) begin
                  if (meter_count_i == '0) begin
                     code_q  <= 3'(DEFAULT_CODE);
                     state_q <= ST_HOLD;
                  end else begin
                     pass2_q <= 1'b0;
                     state_q <= ST_DIV;
                  end
               end
            end
            ST_DIV: begin
               if (div_done) begin
                  if (!pass2_q) begin
                     pass2_q <= 1'b1;
                  end else begin
                     code_q  <= div_quo[CODE_W-1:0];
                     state_q <= ST_HOLD;
                  end
               end
            end
            ST_HOLD: state_q <= ST_DONE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign osc_en_o    = (state_q == ST_SETTLE) || (state_q == ST_MEAS) ||
                        (state_q == ST_DIV) || (state_q == ST_HOLD);
   assign meter_en_o  = (state_q == ST_MEAS);
   assign done_o      = (state_q == ST_DONE);
   assign meter_sel_o = port_q;
   assign slew_code_o = code_q;

endmodule

// File: rtl/srcal_seq_chk.sv
module srcal_seq_chk #(
   parameter int PORT_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              osc_en_o,
   input logic              meter_en_o,
   input logic [PORT_W-1:0] meter_sel_o,
   input logic [2:0]        slew_code_o,
   input logic              done_o
);

   // R2: the oscillator only turns on in answer to a start request
   p_osc_rise_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(osc_en_o) |-> $past(start_i));

   // R3: the meter never runs without the oscillator
   p_meter_in_osc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      meter_en_o |-> osc_en_o);

   // R8: done lasts one cycle
   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8: done follows the oscillator switching off
   p_done_after_osc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!osc_en_o && $past(osc_en_o)));

   // R9: the selected port is held for the whole run
   p_sel_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_en_o && $past(osc_en_o)) |-> $stable(meter_sel_o));

   // R10: the code moves only while the oscillator is on
   p_code_moves_with_osc_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(slew_code_o) |-> osc_en_o);

endmodule

bind srcal_seq srcal_seq_chk #(.PORT_W(PORT_W)) u_srcal_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .osc_en_o   (osc_en_o),
   .meter_en_o (meter_en_o),
   .meter_sel_o(meter_sel_o),
   .slew_code_o(slew_code_o),
   .done_o     (done_o)
);

// File: tb/srcal_seq_tb.sv
`timescale 1ns/1ps
module srcal_seq_tb_top;

   localparam int PW = 2;
   localparam int CW = 16;
   localparam int S  = 4;
   localparam int P  = 3;
   localparam int T  = 10;
   localparam int DIV_LAT = 42;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [PW-1:0] port_idx_i = '0;
   logic          meter_valid_i = 1'b0;
   logic [CW-1:0] meter_count_i = '0;
   logic          osc_en_o, meter_en_o, done_o;
   logic [PW-1:0] meter_sel_o;
   logic [2:0]    slew_code_o;

   always #5 clk = ~clk;

   srcal_seq #(
      .PORT_W(PW), .CNT_W(CW), .SETTLE_CYC(S), .POLL_CYC(P), .TIMEOUT_CYC(T)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .port_idx_i(port_idx_i),
      .meter_valid_i(meter_valid_i), .meter_count_i(meter_count_i),
      .osc_en_o(osc_en_o), .meter_en_o(meter_en_o), .meter_sel_o(meter_sel_o),
      .slew_code_o(slew_code_o), .done_o(done_o)
   );

   int n_cmp = 0;
   int n_bad = 0;

   task automatic check(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Reference model: phase 0 idle, 1 settle, 2 measure, 3 divide, 4 hold, 5 done
   int m_phase = 0, m_left = 0, m_i = 0, m_sel = 0, m_code = 4, m_res = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0; m_left = 0; m_i = 0; m_sel = 0; m_code = 4;
      end else begin
         case (m_phase)
            0: if (start_i) begin m_phase = 1; m_left = S; m_sel = int'(port_idx_i); end
            1: begin m_left--; if (m_left == 0) begin m_phase = 2; m_i = 0; end end
            2: begin
               if (((m_i + 1) % P == 0) && (meter_valid_i || (m_i + 1 >= T))) begin
                  if (meter_count_i == 0) begin m_code = 4; m_phase = 4; end
                  else begin
                     m_res = ((745472 / int'(meter_count_i)) + 500) / 1000 % 8;
                     m_phase = 3; m_left = DIV_LAT;
                  end
               end else m_i++;
            end
            3: begin m_left--; if (m_left == 0) begin m_code = m_res; m_phase = 4; end end
            4: m_phase = 5;
            default: m_phase = 0;
         endcase
      end
   end

   // Cycle-by-cycle compare
   always @(negedge clk) begin
      if (rst_n) begin
         check("R2 osc_en", int'(osc_en_o), int'(m_phase >= 1 && m_phase <= 4));
         check("R3 meter_en", int'(meter_en_o), int'(m_phase == 2));
         check("R8 done", int'(done_o), int'(m_phase == 5));
         check("R9 meter_sel", int'(meter_sel_o), m_sel);
         check("R5 slew_code", int'(slew_code_o), m_code);
      end
   end

   // Meter stand-in
   int  cfg_count = 0, cfg_vdel = 0, en_cnt = 0;
   bit  cfg_pulse = 0;
   always @(negedge clk) begin
      if (meter_en_o) en_cnt++; else en_cnt = 0;
      meter_valid_i = cfg_pulse ? (meter_en_o && en_cnt == 1) : (meter_en_o && en_cnt > cfg_vdel);
      meter_count_i = CW'(cfg_count);
   end

   // Run statistics
   int st_settle = 0, st_meas = 0, st_post = 0, st_done = 0;
   bit prev_osc = 0;
   always @(negedge clk) begin
      if (osc_en_o && !prev_osc) begin st_settle = 0; st_meas = 0; st_post = 0; st_done = 0; end
      if (osc_en_o && !meter_en_o && st_meas == 0) st_settle++;
      if (meter_en_o) st_meas++;
      if (osc_en_o && !meter_en_o && st_meas > 0) st_post++;
      if (done_o) st_done++;
      prev_osc = osc_en_o;
   end

   // Watchdog
   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 20000) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual %0d expected below 20000 cycles", wd);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic run_cal(input int port, input int cnt, input int vdel, input bit pulse,
                          input int exp_code, input int exp_meas, input string tag,
                          input bit poke);
      cfg_count = cnt; cfg_vdel = vdel; cfg_pulse = pulse;
      @(negedge clk); start_i = 1'b1; port_idx_i = PW'(port);
      @(negedge clk); start_i = 1'b0; port_idx_i = '0;
      if (poke) begin
         repeat (6) @(negedge clk);
         start_i = 1'b1; port_idx_i = PW'(port + 1);
         @(negedge clk); start_i = 1'b0; port_idx_i = '0;
      end
      for (int k = 0; k < 400 && !done_o; k++) @(negedge clk);
      check({tag, " code"}, int'(slew_code_o), exp_code);
      @(negedge clk);
      check("R2 settle cycles", st_settle, S);
      check({tag, " measure cycles"}, st_meas, exp_meas);
      check("R7 post-measure osc cycles", st_post, (cnt == 0) ? 1 : DIV_LAT + 1);
      check("R8 done pulses", st_done, 1);
      check("R9 port held", int'(meter_sel_o), port);
      repeat (4) @(negedge clk);
      check("R10 code held idle", int'(slew_code_o), exp_code);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 osc_en reset", int'(osc_en_o), 0);
      check("R1 meter_en reset", int'(meter_en_o), 0);
      check("R1 done reset", int'(done_o), 0);
      check("R1 sel reset", int'(meter_sel_o), 0);
      check("R1 code preset", int'(slew_code_o), 4);

      run_cal(1, 1024, 3,    0, 1, 6,  "R5 R3", 0);
      run_cal(0, 100,  0,    0, 7, 3,  "R5", 0);
      run_cal(2, 90,   3,    0, 0, 6,  "R5 truncate", 0);
      run_cal(3, 2,    3,    0, 5, 6,  "R5", 0);
      run_cal(1, 497,  0,    0, 1, 3,  "R5 round down", 0);
      run_cal(1, 496,  0,    0, 2, 3,  "R5 round up", 0);
      run_cal(0, 0,    0,    0, 4, 3,  "R6 zero valid", 0);
      run_cal(2, 3000, 1000, 0, 0, 12, "R4 timeout nonzero", 0);
      run_cal(1, 0,    1000, 0, 4, 12, "R6 R4 timeout zero", 0);
      run_cal(3, 1024, 0,    1, 1, 12, "R3 off-poll valid", 0);
      run_cal(2, 100,  3,    0, 7, 6,  "R9 busy start", 1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule